// File: doc/BRIEF.md
# Byte Mask Lane Tester

This block exercises the per-byte write-mask lines of a memory port and reports which lanes fail to block writes, or block them when they should not. After a start pulse it runs a fixed sequence of transactions against address 0 over a request/acknowledge memory handshake. It then raises a one-cycle completion pulse with a per-lane failure vector and an overall fail flag.

With several lanes, each lane i gets three transactions. First a full word of ones is written with no mask bit set. Then a word of zeros is written with only mask bit i set, and finally the word is read back. The read-back is judged against every lane at once. Lane i must still hold 0xFF, because its write was blocked. Every other lane must hold 0x00, because its write went through. When the data width is a single byte there is only one mask line, and a short variant runs instead. It writes 0x55 unmasked, writes 0xAA with the mask set and reads back. A read of 0xAA shows a mask line stuck inactive.

States of the sequencer: `ST_IDLE`, `ST_PRELOAD`, `ST_MASKWR`, `ST_READ`, `ST_JUDGE`, `ST_FINISH`. Transitions:
- `ST_IDLE` goes to `ST_PRELOAD` on start.
- `ST_PRELOAD` goes to `ST_MASKWR`, and `ST_MASKWR` goes to `ST_READ`, each on acknowledge.
- `ST_READ` goes to `ST_JUDGE` on acknowledge, capturing the read data.
- `ST_JUDGE` goes to `ST_PRELOAD` for the next lane, or to `ST_FINISH` after the last lane.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `mask_lane_tester`

## Requirements
- R1: After reset, busy, done, fail, mem_req and every lane_fail bit are 0.
- R2: A start pulse in the idle state begins a run. A start pulse while busy is ignored: the run is not restarted and exactly one done pulse follows.
- R3: With several lanes, the transactions for lane i, for i rising from 0, are issued in this order: a write of all ones with mask 0, a write of all zeros with only mask bit i set, and a read. Every transaction targets address 0. The request, write flag, data and mask stay stable until mem_ack.
- R4: In the read-back for lane i, any other lane j whose byte is not 0x00 sets lane_fail[j].
- R5: In the read-back for lane i, lane i sets lane_fail[i] if its byte is not 0xFF.
- R6: A set lane_fail bit stays set for the rest of the run. All lane_fail bits and fail are cleared when a new run starts.
- R7: When done is high, fail is 1 exactly when at least one lane_fail bit is 1.
- R8: With one lane (DATA_W = 8), the run writes 0x55 unmasked, then writes 0xAA with mask set, then reads. It flags a failure exactly when the read returns 0xAA, so a stale 0xAA at address 0 gives no false failure.
- R9: done is high for exactly one cycle, in the cycle after the last read-back is judged. busy is 0 from the next cycle.
- R10: Lane k is data bits 8k+7 down to 8k, the number of lanes is DATA_W/8, and mem_mask[k] = 1 means lane k must not be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Some lane failed in the last run |
| lane_fail | output | DATA_W/8 | Per-lane failure flags |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address (always 0) |
| mem_wdata | output | DATA_W | Write data |
| mem_mask | output | DATA_W/8 | Per-lane write block, 1 = blocked |
| mem_ack | input | 1 | Acknowledge; read data valid with it |
| mem_rdata | input | DATA_W | Read data |

## Verification
A wrong lane counter or a wrong state shows at the memory port at once. The mask written in the second transaction of a lane names the wrong lane, or the three-step order breaks, and the bench's memory model sees this on the very next request. A faulty judgement or a flag that does not stick shows up only at the done pulse. That pulse comes about seven cycles per lane after start, when lane_fail differs from the vector the bench derives from the fault it injected into its memory model. A stuck or doubled done is visible in the cycle after the pulse.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_MASKWR,
        ST_READ,
        ST_JUDGE,
        ST_FINISH
    } mlt_state_e;

    localparam logic [7:0] SOLO_PRELOAD = 8'h55;
    localparam logic [7:0] SOLO_PATTERN = 8'hAA;
    localparam logic [7:0] BYTE_ONES    = 8'hFF;
    localparam logic [7:0] BYTE_ZERO    = 8'h00;

endpackage

// File: rtl/mlt_sequencer.sv
module mlt_sequencer
    import mlt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_mask,
    output logic [LIDX_W-1:0] lane_sel,
    output logic              capture,
    output logic              judge_en,
    output logic              clear,
    output logic              busy,
    output logic              done
);

    localparam bit SOLO = (LANES == 1);
    localparam logic [LIDX_W-1:0] LAST_LANE = LIDX_W'(LANES - 1);

    mlt_state_e state_q, state_d;
    logic [LIDX_W-1:0] lane_q;

    // state register and lane counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                lane_q <= '0;
            else if (state_q == ST_JUDGE && lane_q != LAST_LANE)
                lane_q <= lane_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   state_d = ST_PRELOAD;
            ST_PRELOAD: if (mem_ack) state_d = ST_MASKWR;
            ST_MASKWR:  if (mem_ack) state_d = ST_READ;
            ST_READ:    if (mem_ack) state_d = ST_JUDGE;
            ST_JUDGE:   state_d = (lane_q == LAST_LANE) ? ST_FINISH : ST_PRELOAD;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_mask  = '0;
        capture   = 1'b0;
        judge_en  = 1'b0;
        clear     = 1'b0;
        done      = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: clear = start;
            ST_PRELOAD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = SOLO ? {LANES{SOLO_PRELOAD}} : {LANES{BYTE_ONES}};
            end
            ST_MASKWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = SOLO ? {LANES{SOLO_PATTERN}} : {LANES{BYTE_ZERO}};
                mem_mask  = LANES'(1) << lane_q;
            end
            ST_READ: begin
                mem_req = 1'b1;
                capture = mem_ack;
            end
            ST_JUDGE:  judge_en = 1'b1;
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign lane_sel = lane_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_mask) && $stable(mem_wdata)));

    // R3
    single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_mask) <= 1));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

// File: rtl/mlt_lane_judge.sv
module mlt_lane_judge
    import mlt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LIDX_W-1:0] lane_sel,
    input  logic [LANES-1:0]  flags_in,
    output logic [LANES-1:0]  flags_out
);

    generate
        if (LANES == 1) begin : g_solo
            // mask stuck inactive lets the pattern land
            assign flags_out[0] = flags_in[0] | (word[7:0] == SOLO_PATTERN);
        end else begin : g_multi
            for (genvar j = 0; j < LANES; j++) begin : g_lane
                logic [7:0] lane_byte;
                logic [7:0] lane_expect;
                assign lane_byte   = word[8*j +: 8];
                assign lane_expect = (lane_sel == LIDX_W'(j)) ? BYTE_ONES : BYTE_ZERO;
                // a flagged lane stays flagged; its compare no longer matters
                assign flags_out[j] = flags_in[j] | (lane_byte != lane_expect);
            end
        end
    endgenerate

endmodule

// File: rtl/mask_lane_tester.sv
module mask_lane_tester
    import mlt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    output logic                  done,
    output logic                  fail,
    output logic [DATA_W/8-1:0]   lane_fail,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_mask,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata
);

    localparam int LANES  = DATA_W / 8;
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LIDX_W-1:0] lane_sel;
    logic              capture;
    logic              judge_en;
    logic              clear;
    logic [DATA_W-1:0] rdata_q;
    logic [LANES-1:0]  flags_q;
    logic [LANES-1:0]  flags_next;
    logic              fail_q;

    mlt_sequencer #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES), .LIDX_W(LIDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_mask (mem_mask),
        .lane_sel (lane_sel),
        .capture  (capture),
        .judge_en (judge_en),
        .clear    (clear),
        .busy     (busy),
        .done     (done)
    );

    mlt_lane_judge #(
        .DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)
    ) u_judge (
        .word     (rdata_q),
        .lane_sel (lane_sel),
        .flags_in (flags_q),
        .flags_out(flags_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            flags_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (capture)
                rdata_q <= mem_rdata;
            if (clear) begin
                flags_q <= '0;
                fail_q  <= 1'b0;
            end else if (judge_en) begin
                flags_q <= flags_next;
                fail_q  <= fail_q | (|flags_next);
            end
        end
    end

    assign lane_fail = flags_q;
    assign fail      = fail_q;

    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((lane_fail & $past(lane_fail)) == $past(lane_fail)));

    // R7
    fail_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail == (lane_fail != '0)));

    // R6
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (lane_fail == '0 && !fail));

endmodule

// File: tb/test_mask_lane_tester.sv
module test_mask_lane_tester;

    localparam int DW = 32;
    localparam int AW = 16;
    localparam int NL = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // ---------------- multi-lane instance ----------------
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic [NL-1:0] lane_fail, mem_mask;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    mask_lane_tester #(.DATA_W(DW), .ADDR_W(AW)) i_mask_lane_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .lane_fail(lane_fail), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_mask(mem_mask),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model with injectable faults
    logic [NL-1:0] f_low = '0;   // mask line ignored
    logic [NL-1:0] f_high = '0;  // lane always blocked
    logic [DW-1:0] f_one = '0;   // data bits read as 1
    logic          preset = 1'b0;
    logic [DW-1:0] preset_val = '0;
    logic [DW-1:0] mem_word;
    int ops = 0;
    int seq_err = 0;
    int done_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (preset) mem_word <= preset_val;
            if (done) done_cnt <= done_cnt + 1;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                ops <= ops + 1;
                if (mem_addr != '0) seq_err <= seq_err + 1;
                case (ops % 3)
                    0: if (!(mem_we && mem_mask == '0 && mem_wdata == '1)) seq_err <= seq_err + 1;
                    1: if (!(mem_we && mem_mask == NL'(1) << (ops / 3) && mem_wdata == '0)) seq_err <= seq_err + 1;
                    default: if (mem_we) seq_err <= seq_err + 1;
                endcase
                if (mem_we) begin
                    for (int k = 0; k < NL; k++)
                        if (!f_high[k] && (f_low[k] || !mem_mask[k]))
                            mem_word[8*k +: 8] <= mem_wdata[8*k +: 8];
                end else begin
                    mem_rdata <= mem_word | f_one;
                end
            end
        end
    end

    // ---------------- single-lane instance ----------------
    logic       s_start = 1'b0;
    logic       s_busy, s_done, s_fail;
    logic [0:0] s_lane_fail, s_mask;
    logic       s_req, s_we, s_ack;
    logic [AW-1:0] s_addr;
    logic [7:0] s_wdata, s_rdata;

    mask_lane_tester #(.DATA_W(8), .ADDR_W(AW)) i_mask_lane_tester_solo (
        .clk(clk), .rst_n(rst_n), .start(s_start), .busy(s_busy), .done(s_done),
        .fail(s_fail), .lane_fail(s_lane_fail), .mem_req(s_req), .mem_we(s_we),
        .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_mask(s_mask),
        .mem_ack(s_ack), .mem_rdata(s_rdata)
    );

    logic       s_flow = 1'b0;
    logic       s_fhigh = 1'b0;
    logic       s_preset = 1'b0;
    logic [7:0] s_preset_val = '0;
    logic [7:0] s_word;
    int s_ops = 0;
    int s_seq_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            s_ack <= 1'b0;
            s_rdata <= '0;
        end else begin
            s_ack <= 1'b0;
            if (s_preset) s_word <= s_preset_val;
            if (s_req && !s_ack) begin
                s_ack <= 1'b1;
                s_ops <= s_ops + 1;
                case (s_ops % 3)
                    0: if (!(s_we && s_mask == 1'b0 && s_wdata == 8'h55)) s_seq_err <= s_seq_err + 1;
                    1: if (!(s_we && s_mask == 1'b1 && s_wdata == 8'hAA)) s_seq_err <= s_seq_err + 1;
                    default: if (s_we) s_seq_err <= s_seq_err + 1;
                endcase
                if (s_we) begin
                    if (!s_fhigh && (s_flow || !s_mask[0])) s_word <= s_wdata;
                end else begin
                    s_rdata <= s_word;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_multi(input logic [NL-1:0] lo, input logic [NL-1:0] hi,
                             input logic [DW-1:0] one, input logic [DW-1:0] init,
                             input bit mid_start, input logic [NL-1:0] exp);
        int t;
        @(negedge clk);
        f_low = lo; f_high = hi; f_one = one;
        preset_val = init; preset = 1'b1;
        @(negedge clk);
        preset = 1'b0; ops = 0; seq_err = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 500) begin
            @(negedge clk);
            t++;
            if (mid_start && t == 5) start = 1'b1;
            if (mid_start && t == 6) start = 1'b0;
        end
        check(done == 1'b1, "R9 done reached", done, 1);
        // R4 R5 R10
        check(lane_fail == exp, "R4/R5 lane_fail", lane_fail, exp);
        // R7
        check(fail == (exp != '0), "R7 fail", fail, exp != '0);
        @(negedge clk);
        // R9
        check(!done && !busy, "R9 single pulse", {done, busy}, 0);
        repeat (20) @(negedge clk);
        // R3
        check(ops == 3 * NL && seq_err == 0, "R3 order", ops * 100 + seq_err, 3 * NL * 100);
        // R2
        check(done_cnt == 1, "R2 one done", done_cnt, 1);
    endtask

    task automatic run_solo(input bit lo, input bit hi, input logic [7:0] init, input bit exp);
        int t;
        @(negedge clk);
        s_flow = lo; s_fhigh = hi; s_preset_val = init; s_preset = 1'b1;
        @(negedge clk);
        s_preset = 1'b0; s_ops = 0; s_seq_err = 0;
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        t = 0;
        while (!s_done && t < 200) begin
            @(negedge clk);
            t++;
        end
        // R8
        check(s_done == 1'b1 && s_fail == exp && s_lane_fail[0] == exp, "R8 solo verdict", s_fail, exp);
        check(s_ops == 3 && s_seq_err == 0, "R8 solo order", s_ops * 100 + s_seq_err, 300);
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !done && !fail && lane_fail == '0 && !mem_req, "R1 reset state",
              {busy, done, fail, lane_fail, mem_req}, 0);
        check(!s_busy && !s_done && !s_fail && !s_req, "R1 reset solo", {s_busy, s_done, s_fail, s_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_multi('0, '0, '0, '0, 1'b0, '0);
        for (int k = 0; k < NL; k++) begin
            run_multi(NL'(1) << k, '0, '0, '0, 1'b0, NL'(1) << k);   // R5
            run_multi('0, NL'(1) << k, '0, '0, 1'b0, NL'(1) << k);   // R5
            run_multi('0, '0, DW'(1) << (8 * k + 3), '0, 1'b0, NL'(1) << k); // R4
        end
        // R4 every mask ignored: each lane fails its own test
        run_multi('1, '0, '0, '0, 1'b0, '1);
        // R6 flags cleared by a clean run after a faulty one
        run_multi('0, '0, '0, '1, 1'b0, '0);
        // R2 start while busy ignored
        run_multi(NL'(2), '0, '0, '0, 1'b1, NL'(2));

        run_solo(1'b0, 1'b0, 8'h00, 1'b0);
        run_solo(1'b0, 1'b0, 8'hAA, 1'b0);   // R8 stale pattern
        run_solo(1'b1, 1'b0, 8'h00, 1'b1);   // R8 stuck inactive
        run_solo(1'b0, 1'b1, 8'h00, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule